// File: doc/BRIEF.md
# Per-Bit Clock-Gated Load Register

A parallel-load register in which each stored bit has its own gated clock. A bit's flip-flop only receives a clock pulse when two things are true: the load control is high, and the incoming data bit differs from the value already stored. In every other cycle that flip-flop sees no clock edge, so it does not switch. The free-running clock keeps toggling the whole time. Seen from its ports, the register behaves exactly like an ungated register with a load enable.

Each gate decision is held in a latch that is transparent only while the clock is low. As a result, the decision is frozen for the whole high phase. A bit's flip-flop updates on the rising edge of its gated clock. That update changes the comparison result, but it cannot cut the pulse short. The gated clock is the AND of the clock and the latched decision, so every pulse it carries is a full high phase with no glitch.

An active-low asynchronous set forces every bit to 1 at once and suppresses all gated clocks while it is held. The gated clocks are brought out as ports so that switching activity can be observed.

Top module: `cg_load_reg`

## Requirements
- R1: While `rst_ni` is 0, `data_o` is all ones. It changes to all ones without waiting for a clock edge.
- R2: While `rst_ni` is 0, every bit of `gclk_o` stays 0 and `data_o` stays all ones, whatever `load_i` and `data_i` are.
- R3: At a rising clock edge with `load_i` = 1, `data_o` takes the value of `data_i` sampled at that edge.
- R4: At a rising clock edge with `load_i` = 0, `data_o` is unchanged and no bit of `gclk_o` pulses in that cycle.
- R5: Bit k of `gclk_o` pulses in a cycle if and only if, at that rising edge, `load_i` = 1 and `data_i[k]` differs from `data_o[k]`.
- R6: A pulse on `gclk_o` rises with the clock, stays high for the whole high phase, and is 0 for the whole low phase.
- R7: Holding a constant loaded word for many cycles produces zero gated pulses on every bit. Loading a word that inverts every cycle produces exactly one pulse per cycle on every bit.
- R8: The first rising edge after `rst_ni` returns to 1 loads normally. A set applied during a low phase takes effect before the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Asynchronous set, active low; forces all bits to 1 |
| load_i | input | 1 | 1 = load `data_i` at the edge, 0 = hold |
| data_i | input | W | Data word to load |
| data_o | output | W | Stored word |
| gclk_o | output | W | Per-bit gated clocks, exposed for observation |

## Verification
The assertions assume that `load_i`, `data_i` and the assertion and release of `rst_ni` change only while the clock is low. This is the window in which the gate latches are transparent, so a change there cannot reshape a pulse that is already running. The bench respects this: it applies every input change just after a falling edge, and it applies the set a short time into a low phase. It then samples shortly after the rising edge and again just before the falling edge, which brackets each gated pulse.

// File: rtl/cg_pkg.sv
package cg_pkg;
  localparam int unsigned REG_W = 32;
  localparam logic SET_VAL = 1'b1;
endpackage

// File: rtl/cg_cell.sv
// Latch-held clock gate: decision frozen during the high phase.
module cg_cell (
  input  logic clk_i,
  input  logic en_i,
  output logic gclk_o
);
  logic en_q;

  always_latch begin
    if (!clk_i) en_q <= en_i;
  end

  assign gclk_o = clk_i & en_q;
endmodule

// File: rtl/cg_bit.sv
module cg_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic d_i,
  output logic q_o,
  output logic gclk_o
);
  logic q_q;
  logic same;
  logic en;

  assign same = ~(d_i ^ q_q);
  // Enable masked by set so no pulse reaches a flop held in set.
  assign en   = rst_ni & load_i & ~same;

  cg_cell u_cell (
    .clk_i  (clk_i),
    .en_i   (en),
    .gclk_o (gclk_o)
  );

  always_ff @(posedge gclk_o or negedge rst_ni) begin
    if (!rst_ni) q_q <= cg_pkg::SET_VAL;
    else         q_q <= d_i;
  end

  assign q_o = q_q;
endmodule

// File: rtl/cg_load_reg.sv
module cg_load_reg #(
  parameter int unsigned W = cg_pkg::REG_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] data_o,
  output logic [W-1:0] gclk_o
);
  for (genvar k = 0; k < W; k++) begin : g_bit
    cg_bit u_bit (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (load_i),
      .d_i    (data_i[k]),
      .q_o    (data_o[k]),
      .gclk_o (gclk_o[k])
    );
  end
endmodule

// File: rtl/cg_load_reg_chk.sv
module cg_load_reg_chk #(
  parameter int unsigned W = cg_pkg::REG_W
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         load_i,
  input logic [W-1:0] data_i,
  input logic [W-1:0] data_o,
  input logic [W-1:0] gclk_o
);
  p_set_ones_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (data_o == {W{1'b1}}));

  p_set_quiet_r2: assert property (@(negedge clk_i)
    !rst_ni |-> (gclk_o == '0));

  p_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_ni && load_i) |=> (data_o == $past(data_i)));

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_ni && !load_i) |=> $stable(data_o));

  // High-phase gclk value seen at falling edge equals the bits that changed.
  p_pulse_match_r5: assert property (@(negedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (gclk_o == (data_o ^ $past(data_o))));

  p_low_phase_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gclk_o == '0);
endmodule

bind cg_load_reg cg_load_reg_chk #(.W(W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .load_i (load_i),
  .data_i (data_i),
  .data_o (data_o),
  .gclk_o (gclk_o)
);

// File: tb/cg_load_reg_tb.sv
module cg_load_reg_tb;
  localparam int W = 32;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = CLK_PERIOD / 2;
  localparam int NV = 8;

  typedef struct packed {
    logic         ld;
    logic [W-1:0] d;
    logic [W-1:0] q;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b1, 32'h0000_0000, 32'h0000_0000},
    '{1'b0, 32'hFFFF_FFFF, 32'h0000_0000},
    '{1'b1, 32'hA5A5_5A5A, 32'hA5A5_5A5A},
    '{1'b1, 32'hA5A5_5A5A, 32'hA5A5_5A5A},
    '{1'b0, 32'h0000_0000, 32'hA5A5_5A5A},
    '{1'b1, 32'hFFFF_0000, 32'hFFFF_0000},
    '{1'b1, 32'h0000_FFFF, 32'h0000_FFFF},
    '{1'b0, 32'h1234_5678, 32'h0000_FFFF}
  };

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b1;
  logic         load_i = 1'b0;
  logic [W-1:0] data_i = '0;
  logic [W-1:0] data_o;
  logic [W-1:0] gclk_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;
  logic [W-1:0] model = '1;
  int pulse_cnt [W];

  cg_load_reg #(.W(W)) u_dut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .data_i (data_i),
    .data_o (data_o),
    .gclk_o (gclk_o)
  );

  always #(HALF) clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clr_cnt();
    for (int i = 0; i < W; i++) pulse_cnt[i] = 0;
  endtask

  // Called in a low phase; returns 1 time unit after the next falling edge.
  task automatic step(input logic ld, input logic [W-1:0] d, input string req);
    logic [W-1:0] exp_g;
    logic [W-1:0] hi_a;
    logic [W-1:0] hi_b;
    load_i = ld;
    data_i = d;
    exp_g  = ld ? (d ^ model) : '0;
    if (ld) model = d;
    @(posedge clk_i);
    #1;
    hi_a = gclk_o;
    for (int i = 0; i < W; i++) pulse_cnt[i] += int'(hi_a[i]);
    chk(data_o == model, {req, " data"}, data_o, model);
    chk(hi_a == exp_g, "R5 gated pulses", hi_a, exp_g);
    #(HALF - 2);
    hi_b = gclk_o;
    chk(hi_b == hi_a, "R6 pulse held whole high phase", hi_b, hi_a);
    #2;
    chk(gclk_o == '0, "R6 low phase quiet", gclk_o, '0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    clr_cnt();
    #1;
    rst_ni = 1'b0;
    load_i = 1'b1;
    data_i = '0;
    #1;
    chk(data_o == '1, "R1 set before any edge", data_o, '1);
    repeat (3) begin
      @(posedge clk_i);
      #1;
      chk(gclk_o == '0, "R2 no pulses in set", gclk_o, '0);
      chk(data_o == '1, "R2 set holds ones", data_o, '1);
    end
    @(negedge clk_i);
    #1;
    rst_ni = 1'b1;
    model  = '1;

    // Vector table walk (first vector is the first edge after release: R8)
    for (int v = 0; v < NV; v++) begin
      step(VECS[v].ld, VECS[v].d, VECS[v].ld ? "R3 load" : "R4 hold");
      chk(data_o == VECS[v].q, "R3/R4 table", data_o, VECS[v].q);
    end

    // R4: hold with every bit differing -> no pulses
    step(1'b0, ~model, "R4 hold differing");

    // R7: constant input -> zero pulses
    step(1'b1, 32'h3C3C_C3C3, "R3 load");
    clr_cnt();
    for (int c = 0; c < 20; c++) step(1'b1, 32'h3C3C_C3C3, "R7 constant");
    begin
      int tot = 0;
      for (int i = 0; i < W; i++) tot += pulse_cnt[i];
      chk(tot == 0, "R7 constant gives zero pulses", W'(tot), '0);
    end

    // R7: toggling input -> one pulse per cycle per bit
    clr_cnt();
    for (int c = 0; c < 20; c++) step(1'b1, ~model, "R7 toggle");
    begin
      int bad = 0;
      for (int i = 0; i < W; i++) if (pulse_cnt[i] != 20) bad++;
      chk(bad == 0, "R7 toggle gives one pulse per cycle", W'(pulse_cnt[0]), W'(20));
    end

    // R8: set applied in a low phase acts at once; first edge after release loads
    step(1'b1, 32'h0000_0001, "R3 load");
    #1;
    rst_ni = 1'b0;
    #1;
    chk(data_o == '1, "R8 mid-cycle set", data_o, '1);
    chk(gclk_o == '0, "R2 set low phase", gclk_o, '0);
    load_i = 1'b1;
    data_i = 32'h0F0F_0F0F;
    @(posedge clk_i);
    #1;
    chk(gclk_o == '0, "R2 load ignored in set", gclk_o, '0);
    chk(data_o == '1, "R2 load ignored in set", data_o, '1);
    @(negedge clk_i);
    #1;
    rst_ni = 1'b1;
    model  = '1;
    step(1'b1, 32'h0F0F_0F0F, "R8 first edge after release");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule